// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two 32-bit operands over many clock cycles, retiring one multiplier bit per iteration. A single 64-bit accumulator holds the multiplier in its lower half and the growing partial product in its upper half. One 32-bit adder adds the held multiplicand into the upper half whenever the bit about to leave the bottom of the accumulator is set. The accumulator then moves right by one place. The adder's carry-out enters the top bit, so no unsigned overflow is lost.

A mode input selects unsigned or signed (two's complement) operation. In signed mode both operands are first replaced by their magnitudes, and the sign of the result is recorded. The accumulator runs one iteration fewer, because the magnitude's top bit is zero. The aligned magnitude is then negated if the operand signs differed. The one operand that keeps its top bit set is the most negative multiplier. For that operand the full 32 iterations are run, so no magnitude overflows.

Operands arrive on a valid/ready handshake. `in_ready` is high only while the block is idle, and a transfer happens on a rising edge where both `in_valid` and `in_ready` are high. Holding `in_valid` high while `in_ready` is low is legal back-pressure. The operands are not taken, and the source must present them again once `in_ready` returns. The result has no back-pressure: `done` is a one-cycle pulse, and the result words then stay put until the next operation completes.

Top module: `seq_shift_mult`

## Requirements
- R1: After reset, and whenever no operation is in progress, `in_ready` is 1. It falls in the cycle after an accepted transfer and stays 0 until the `done` cycle. On acceptance the upper accumulator half is cleared and the lower half is loaded with `op_b`.
- R2: With `is_signed` = 0, `{res_hi, res_lo}` equals the full 64-bit unsigned product of `op_a` and `op_b`, including cases where the adder carries out (for example all-ones times all-ones).
- R3: `res_hi` carries product bits 63..32 and `res_lo` carries bits 31..0.
- R4: With `is_signed` = 1, `{res_hi, res_lo}` equals the 64-bit two's-complement product of the signed operands.
- R5: In signed mode, the value 0x80000000 as either operand, or as both, gives the exact product (for example 0x80000000 × 0x80000000 = 0x4000000000000000).
- R6: A zero multiplicand or a zero multiplier gives a product of 0 in both modes, never a negated zero pattern.
- R7: Counting the accepting edge as edge 0, `done` is high in the cycle that follows edge N+1. N is 32 in unsigned mode and 31 in signed mode, except that N is 32 in signed mode when `op_b` is 0x80000000.
- R8: `done` is high for exactly one cycle per accepted operation.
- R9: `in_valid` pulses and operand changes while `in_ready` is 0 have no effect: the result is that of the accepted operands.
- R10: `res_hi` and `res_lo` change only in the cycle where `done` rises, and they hold their value between operations.
- R11: During reset `done` is 0 and both result words are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand transfer request |
| in_ready | output | 1 | Block idle and able to take operands |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| done | output | 1 | One-cycle pulse: result words updated |
| res_hi | output | 32 | Upper product word |
| res_lo | output | 32 | Lower product word |

## Verification
The assertions assume the operands and `is_signed` are only sampled on the accepting edge. They also assume that `in_valid` is a clean level synchronous to `clk`, so the skip-add and load checks compare the accumulator against the operands present at that edge. The bench drives every input half a cycle away from the rising edge. It lowers `in_valid` right after each transfer, and it only changes operands while busy in the dedicated test that shows they are ignored. This keeps the stimulus inside what the properties take for granted.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } smul_state_e;
endpackage

// File: rtl/smul_operand_prep.sv
module smul_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         is_signed,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         neg_res,
  output logic         short_run
);
  logic a_neg, b_neg;

  always_comb begin
    a_neg = is_signed & op_a[W-1];
    b_neg = is_signed & op_b[W-1];
    // magnitude of the most negative value is 2^(W-1), which fits unsigned W bits
    mag_a = a_neg ? (~op_a + 1'b1) : op_a;
    mag_b = b_neg ? (~op_b + 1'b1) : op_b;
    neg_res = a_neg ^ b_neg;
    // top multiplier bit is clear for every signed magnitude but one
    short_run = is_signed & ~mag_b[W-1];
  end
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic short_run,
  output logic in_ready,
  output logic load,
  output logic step,
  output logic fix
);
  localparam int CW = $clog2(W + 1);

  smul_state_e    state;
  logic [CW-1:0]  cnt;

  assign in_ready = (state == ST_IDLE);
  assign load     = in_valid & in_ready;
  assign step     = (state == ST_RUN);
  assign fix      = (state == ST_FIX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (load) begin
          state <= ST_RUN;
          cnt   <= short_run ? CW'(W - 1) : CW'(W);
        end
        ST_RUN: begin
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!in_ready && step));

  // R7
  iter_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt != '0 && cnt <= CW'(W)));
endmodule

// File: rtl/smul_datapath.sv
module smul_datapath #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic [2*W-1:0] prod
);
  logic [W-1:0] mcand_q;
  logic [W:0]   sum;

  always_comb begin
    sum = {1'b0, prod[2*W-1:W]} + (prod[0] ? {1'b0, mcand_q} : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod    <= '0;
      mcand_q <= '0;
    end else if (load) begin
      prod    <= {{W{1'b0}}, mplier_in};
      mcand_q <= mcand_in;
    end else if (step) begin
      // carry-out lands in the top bit as the register moves right
      prod <= {sum, prod[W-1:1]};
    end
  end

  // R1
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (prod[2*W-1:W] == '0 && prod[W-1:0] == $past(mplier_in)));

  // R2
  skip_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !prod[0]) |=> (prod == ($past(prod) >> 1)));
endmodule

// File: rtl/smul_result.sv
module smul_result #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           fix,
  input  logic           neg_in,
  input  logic           short_in,
  input  logic [2*W-1:0] prod,
  output logic           done,
  output logic [W-1:0]   res_hi,
  output logic [W-1:0]   res_lo
);
  logic           neg_q, short_q;
  logic [2*W-1:0] aligned, final_v;

  always_comb begin
    aligned = short_q ? (prod >> 1) : prod;
    final_v = neg_q ? (~aligned + 1'b1) : aligned;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q   <= 1'b0;
      short_q <= 1'b0;
      done    <= 1'b0;
      res_hi  <= '0;
      res_lo  <= '0;
    end else begin
      done <= fix;
      if (load) begin
        neg_q   <= neg_in;
        short_q <= short_in;
      end
      if (fix) begin
        res_hi <= final_v[2*W-1:W];
        res_lo <= final_v[W-1:0];
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({res_hi, res_lo}));

  // R6
  zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fix && prod == '0) |=> ({res_hi, res_lo} == '0));
endmodule

// File: rtl/seq_shift_mult.sv
module seq_shift_mult #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         is_signed,
  output logic         done,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  logic [W-1:0]   mag_a, mag_b;
  logic           neg_res, short_run;
  logic           load, step, fix;
  logic [2*W-1:0] prod;

  smul_operand_prep #(.W(W)) prep_i (
    .op_a      (op_a),
    .op_b      (op_b),
    .is_signed (is_signed),
    .mag_a     (mag_a),
    .mag_b     (mag_b),
    .neg_res   (neg_res),
    .short_run (short_run)
  );

  smul_ctrl #(.W(W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .short_run (short_run),
    .in_ready  (in_ready),
    .load      (load),
    .step      (step),
    .fix       (fix)
  );

  smul_datapath #(.W(W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .mcand_in  (mag_a),
    .mplier_in (mag_b),
    .prod      (prod)
  );

  smul_result #(.W(W)) res_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .fix      (fix),
    .neg_in   (neg_res),
    .short_in (short_run),
    .prod     (prod),
    .done     (done),
    .res_hi   (res_hi),
    .res_lo   (res_lo)
  );

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> !$rose(in_ready) || done);
endmodule

// File: tb/seq_shift_mult_tb.sv
`timescale 1ns/1ps
module seq_shift_mult_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] op_a = '0, op_b = '0;
  logic        is_signed = 1'b0;
  logic        done;
  logic [31:0] res_hi, res_lo;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  seq_shift_mult dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .is_signed(is_signed),
    .done(done), .res_hi(res_hi), .res_lo(res_lo)
  );

  // {op_a, op_b, is_signed}
  localparam logic [64:0] VEC [13] = '{
    {32'h00000003, 32'h00000002, 1'b0},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0},
    {32'h00000000, 32'h12345678, 1'b0},
    {32'h89ABCDEF, 32'h00000000, 1'b0},
    {32'hFFFFFFFD, 32'h00000002, 1'b1},
    {32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1},
    {32'h80000000, 32'h80000000, 1'b1},
    {32'h80000000, 32'h00000001, 1'b1},
    {32'h00000001, 32'h80000000, 1'b1},
    {32'h00000000, 32'h80000000, 1'b1},
    {32'hFFFFFFF9, 32'hFFFFFFFB, 1'b1},
    {32'hDEADBEEF, 32'h12345678, 1'b0},
    {32'h80000000, 32'hFFFFFFFF, 1'b0}
  };

  function automatic logic [63:0] ref_mul(logic [31:0] a, logic [31:0] b, logic s);
    logic [63:0] xa, xb;
    xa = s ? {{32{a[31]}}, a} : {32'b0, a};
    xb = s ? {{32{b[31]}}, b} : {32'b0, b};
    return xa * xb;
  endfunction

  function automatic int ref_lat(logic [31:0] b, logic s);
    int n;
    n = (s && b != 32'h80000000) ? 31 : 32;
    return n + 1;
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // returns edges counted after accepting edge until done seen
  task automatic run_op(logic [31:0] a, logic [31:0] b, logic s, output int lat);
    @(negedge clk);
    op_a = a; op_b = b; is_signed = s; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 ready low after accept", {63'b0, in_ready}, 64'd0);
    lat = 0;
    while (!done && lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: got hung expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R11 reset values
    check("R11 done in reset", {63'b0, done}, 64'd0);
    check("R11 result in reset", {res_hi, res_lo}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {63'b0, in_ready}, 64'd1);

    foreach (VEC[i]) begin
      logic [31:0] a, b;
      logic s;
      string req;
      a = VEC[i][64:33]; b = VEC[i][32:1]; s = VEC[i][0];
      req = s ? "R4 signed product" : "R2 unsigned product";
      if (a == 0 || b == 0) req = "R6 zero operand";
      else if (s && (a == 32'h80000000 || b == 32'h80000000)) req = "R5 most negative";
      run_op(a, b, s, lat);
      check(req, {res_hi, res_lo}, ref_mul(a, b, s));
      check("R7 latency", 64'(lat), 64'(ref_lat(b, s)));
      check("R1 ready at done", {63'b0, in_ready}, 64'd1);
      @(negedge clk);
      check("R8 single pulse", {63'b0, done}, 64'd0);
    end

    // R3 word split
    run_op(32'h00010000, 32'h00030000, 1'b0, lat);
    check("R3 high word", {32'b0, res_hi}, 64'h3);
    check("R3 low word", {32'b0, res_lo}, 64'h0);

    // R10 hold between operations
    held = {res_hi, res_lo};
    repeat (20) @(negedge clk);
    check("R10 result held idle", {res_hi, res_lo}, held);

    // R9 busy input ignored, R10 stable while busy
    @(negedge clk);
    op_a = 32'd1000; op_b = 32'd77; is_signed = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_a = 32'hFFFF0000; op_b = 32'h0000FFFF; is_signed = 1'b1;
    repeat (6) @(negedge clk);
    check("R10 result stable while busy", {res_hi, res_lo}, held);
    in_valid = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    check("R9 busy request ignored", {res_hi, res_lo}, 64'd77000);
    @(negedge clk);
    check("R9 no second run", {63'b0, in_ready}, 64'd1);
    repeat (40) @(negedge clk);
    check("R9 no extra done", {res_hi, res_lo}, 64'd77000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule